// File: doc/BRIEF.md
# Backlight PWM with locked update

This block drives a backlight dimming signal as a pulse-width-modulated output. Software programs it through a narrow write port that reaches three words: a period word, a duty word and a lock word. The period word holds a period value and a bit-count selector. The duty word holds a 16-bit active count, an output enable and a fractional-mode flag. The bit-count selector decides how many upper bits of the active count form the whole number of high clocks; the remaining lower bits are a fraction.

Every write lands in a shadow copy first. A write made while the lock is open raises an update-pending flag. Closing the lock holds all shadow writes back, and reopening it raises the flag. The shadow copy moves to the live copy only on the last clock of a PWM period, and the flag drops on that same edge. This lets software change period and duty together without a torn period. Software then polls `upd_pending` until it reads 0.

In fractional mode, the unused low bits of the active count are summed once per period. Each carry out of that sum stretches one period's high time by one clock, so the average duty follows the full 16-bit value.

Top module: `bl_pwm_lockupd`

## Requirements
- R1: After reset, both shadow and live words hold the defaults: duty word 0xC000FA00 and period word 0x000C0FA0. The pending flag is 0 and the period counter is 0, so the first period lasts 4001 clocks with 4000 of them high.
- R2: Period word bits [19:16] give a bit count N and bits [15:0] give a period value. The counter runs from 0 up to the period value masked to its low N bits (the limit), then returns to 0. A period therefore lasts limit+1 clocks, and `prd_wrap` is high only in its last clock.
- R3: A bit-count field of 0 selects N = 16.
- R4: When the masked period value is 0, the limit is 0xFFFF, giving a 65536-clock period.
- R5: Duty word bits [15:0] are the active count. Its top N bits form the integer part I. The output is high in the clocks whose counter value is below I, and is high for the whole period when I exceeds the limit. With fractional mode off (bit 30 = 0), the low 16-N bits have no effect.
- R6: Duty word bit 31 is the output enable. While the live enable is 0, `pwm_out` stays low.
- R7: With duty word bit 30 = 1, the low 16-N bits of the active count are added into an accumulator at each period start. A carry out of that addition makes that period's high time I+1.
- R8: Writes with `wr_sel` = 0 (period) or 1 (duty) go to the shadow words. Such a write made while unlocked sets `upd_pending`. At the end of the next period the live words take the shadow values, and `upd_pending` clears on that same edge. The live words change at no other time.
- R9: Lock word bit 0 (`wr_sel` = 2) is the lock. While it is 1, shadow writes do not set `upd_pending` and the live words do not change.
- R10: Writing the lock bit from 1 to 0 sets `upd_pending` on that edge. The held shadow values go live at the end of the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for one word |
| wr_sel | input | 2 | Word select: 0 period, 1 duty, 2 lock |
| wr_data | input | 32 | Write data |
| pwm_out | output | 1 | Backlight PWM output |
| prd_wrap | output | 1 | High in the last clock of each period |
| upd_pending | output | 1 | Shadow values are waiting to go live |

## Verification
The bound checker watches, on every clock, that:
- the live words stay frozen while the lock is held;
- the live words change only on a period's last clock;
- the pending flag drops only there, and rises whenever the lock opens;
- the counter never passes the limit;
- the output is dark while disabled.

Only the bench scenarios can show the measured figures:
- high-time and period-length counts for each bit-count and period setting, including the 16-bit and 0xFFFF cases;
- the alternating high times of fractional mode;
- that masked fraction bits are ignored;
- that values held behind the lock appear only after release.

// File: rtl/bl_pwm_pkg.sv
// Package: shared widths, word field positions, config types and the
// decode helpers used by the backlight PWM block.
// Assumes a 16-bit active count and 32-bit software words.
package bl_pwm_pkg;

    localparam int DUTY_W   = 16;
    localparam int BCNT_W   = 4;
    localparam int WORD_W   = 32;
    localparam int SEL_W    = 2;
    localparam int NB_W     = $clog2(DUTY_W) + 1;

    localparam int PRD_LSB  = 0;
    localparam int BCNT_LSB = 16;
    localparam int ACT_LSB  = 0;
    localparam int FRAC_BIT = 30;
    localparam int EN_BIT   = 31;
    localparam int LOCK_BIT = 0;

    typedef enum logic [SEL_W-1:0] {
        SEL_PERIOD = 2'd0,
        SEL_DUTY   = 2'd1,
        SEL_LOCK   = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic [BCNT_W-1:0] bcnt;
        logic [DUTY_W-1:0] prd;
    } prd_cfg_t;

    typedef struct packed {
        logic              en;
        logic              frac;
        logic [DUTY_W-1:0] act;
    } duty_cfg_t;

    // Pull the period fields out of a software word.
    function automatic prd_cfg_t word_to_prd(input logic [WORD_W-1:0] w);
        prd_cfg_t c;
        c.prd  = w[PRD_LSB +: DUTY_W];
        c.bcnt = w[BCNT_LSB +: BCNT_W];
        return c;
    endfunction

    // Pull the duty fields out of a software word.
    function automatic duty_cfg_t word_to_duty(input logic [WORD_W-1:0] w);
        duty_cfg_t c;
        c.act  = w[ACT_LSB +: DUTY_W];
        c.frac = w[FRAC_BIT];
        c.en   = w[EN_BIT];
        return c;
    endfunction

    // Effective bit count: a zero field stands for the full duty width.
    function automatic logic [NB_W-1:0] eff_bits(input logic [BCNT_W-1:0] b);
        return (b == '0) ? NB_W'(DUTY_W) : NB_W'(b);
    endfunction

    // Counter limit: period masked to N bits, zero replaced by all ones.
    function automatic logic [DUTY_W-1:0] prd_limit(input prd_cfg_t c);
        logic [DUTY_W:0]   m;
        logic [DUTY_W-1:0] p;
        m = ((DUTY_W+1)'(1) << eff_bits(c.bcnt)) - (DUTY_W+1)'(1);
        p = c.prd & m[DUTY_W-1:0];
        return (p == '0) ? '1 : p;
    endfunction

    // Integer high count: the top N bits of the active count.
    function automatic logic [DUTY_W-1:0] int_part(input logic [DUTY_W-1:0] act,
                                                    input logic [NB_W-1:0]   n);
        return act >> (NB_W'(DUTY_W) - n);
    endfunction

    // Fraction bits moved to the top of a DUTY_W-wide field.
    function automatic logic [DUTY_W-1:0] frac_top(input logic [DUTY_W-1:0] act,
                                                    input logic [NB_W-1:0]   n);
        return act << n;
    endfunction

endpackage

// File: rtl/bl_pwm_regfile.sv
// Shadow/live register bank with lock and update-pending flag.
// All data writes land in the shadow words. The live words load from the
// shadow words on a period wrap when an update is pending and the lock is open.
// Assumes wrap is a single-cycle pulse from the timebase.
module bl_pwm_regfile
    import bl_pwm_pkg::*;
#(
    parameter logic [WORD_W-1:0] DEF_PRD_WORD  = 32'h000C_0FA0,
    parameter logic [WORD_W-1:0] DEF_DUTY_WORD = 32'hC000_FA00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              wrap,
    output prd_cfg_t          live_prd,
    output duty_cfg_t         live_duty,
    output prd_cfg_t          nxt_prd,
    output duty_cfg_t         nxt_duty,
    output logic              lock_q,
    output logic              pend_q
);

    localparam prd_cfg_t  PRD_RST  = word_to_prd(DEF_PRD_WORD);
    localparam duty_cfg_t DUTY_RST = word_to_duty(DEF_DUTY_WORD);

    prd_cfg_t  sh_prd;
    duty_cfg_t sh_duty;
    logic      load;
    logic      data_wr;
    logic      unlock_wr;
    logic      pend_set;

    assign data_wr   = wr_en && (wr_sel == SEL_PERIOD || wr_sel == SEL_DUTY);
    assign unlock_wr = wr_en && (wr_sel == SEL_LOCK) && lock_q && !wr_data[LOCK_BIT];
    assign pend_set  = (data_wr && !lock_q) || unlock_wr;
    assign load      = wrap && pend_q && !lock_q;

    assign nxt_prd   = load ? sh_prd  : live_prd;
    assign nxt_duty  = load ? sh_duty : live_duty;

    // Capture software writes into the shadow words and the lock bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_prd  <= PRD_RST;
            sh_duty <= DUTY_RST;
            lock_q  <= 1'b0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_PERIOD: sh_prd  <= word_to_prd(wr_data);
                SEL_DUTY:   sh_duty <= word_to_duty(wr_data);
                SEL_LOCK:   lock_q  <= wr_data[LOCK_BIT];
                default:    ;
            endcase
        end
    end

    // Move shadow words to live words at an unlocked, pending period wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_prd  <= PRD_RST;
            live_duty <= DUTY_RST;
        end else if (load) begin
            live_prd  <= sh_prd;
            live_duty <= sh_duty;
        end
    end

    // Track the pending flag; a new request wins over the clear on a load.
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (pend_set) pend_q <= 1'b1;
        else if (load)     pend_q <= 1'b0;
    end

endmodule

// File: rtl/bl_pwm_timebase.sv
// Period counter: counts from zero up to the limit and then restarts.
// Flags the last clock of each period. Assumes the limit changes only on a wrap.
module bl_pwm_timebase #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt_q,
    output logic         wrap
);

    assign wrap = (cnt_q >= limit);

    // Advance the period counter, restarting after the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (wrap) cnt_q <= '0;
        else           cnt_q <= cnt_q + W'(1);
    end

endmodule

// File: rtl/bl_pwm_dither.sv
// Fraction accumulator for fractional duty mode.
// On each period wrap, adds the fraction of the upcoming period into an
// accumulator. The carry out grants one extra high clock for that period.
// Clears when fractional mode is off. Assumes frac_top is top-aligned.
module bl_pwm_dither #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wrap,
    input  logic         frac_en,
    input  logic [W-1:0] frac_top,
    output logic         extra_q
);

    logic [W-1:0] acc_q;
    logic [W:0]   sum;

    assign sum = {1'b0, acc_q} + {1'b0, frac_top};

    // Accumulate once per period and register the carry for that period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            extra_q <= 1'b0;
        end else if (wrap) begin
            if (frac_en) begin
                acc_q   <= sum[W-1:0];
                extra_q <= sum[W];
            end else begin
                acc_q   <= '0;
                extra_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/bl_pwm_lockupd.sv
// Top: backlight PWM with shadowed, lockable configuration.
// Ties together the register bank, the period timebase and the fraction
// accumulator, and forms the gated output compare.
// Assumes one register write per clock on a simple strobe port.
module bl_pwm_lockupd
    import bl_pwm_pkg::*;
#(
    parameter logic [31:0] DEF_PRD_WORD  = 32'h000C_0FA0,
    parameter logic [31:0] DEF_DUTY_WORD = 32'hC000_FA00
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    output logic        pwm_out,
    output logic        prd_wrap,
    output logic        upd_pending
);

    prd_cfg_t          live_prd;
    duty_cfg_t         live_duty;
    prd_cfg_t          nxt_prd;
    duty_cfg_t         nxt_duty;
    logic              lock_q;
    logic              wrap;
    logic              extra;
    logic [DUTY_W-1:0] cnt;
    logic [DUTY_W-1:0] limit;
    logic [NB_W-1:0]   live_n;
    logic [NB_W-1:0]   nxt_n;
    logic [DUTY_W-1:0] ipart;
    logic [DUTY_W:0]   hi_cnt;

    // Flattened live fields, also used by the bound checker.
    logic              live_en_w;
    logic [DUTY_W-1:0] live_act_w;
    logic [DUTY_W-1:0] live_prdv_w;
    logic [BCNT_W-1:0] live_bcnt_w;

    bl_pwm_regfile #(
        .DEF_PRD_WORD  (DEF_PRD_WORD),
        .DEF_DUTY_WORD (DEF_DUTY_WORD)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .wrap      (wrap),
        .live_prd  (live_prd),
        .live_duty (live_duty),
        .nxt_prd   (nxt_prd),
        .nxt_duty  (nxt_duty),
        .lock_q    (lock_q),
        .pend_q    (upd_pending)
    );

    assign limit = prd_limit(live_prd);

    bl_pwm_timebase #(.W(DUTY_W)) u_tb (
        .clk   (clk),
        .rst_n (rst_n),
        .limit (limit),
        .cnt_q (cnt),
        .wrap  (wrap)
    );

    assign nxt_n = eff_bits(nxt_prd.bcnt);

    bl_pwm_dither #(.W(DUTY_W)) u_dith (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap     (wrap),
        .frac_en  (nxt_duty.frac),
        .frac_top (frac_top(nxt_duty.act, nxt_n)),
        .extra_q  (extra)
    );

    assign live_n      = eff_bits(live_prd.bcnt);
    assign ipart       = int_part(live_duty.act, live_n);
    assign hi_cnt      = {1'b0, ipart} + {{DUTY_W{1'b0}}, extra};

    assign live_en_w   = live_duty.en;
    assign live_act_w  = live_duty.act;
    assign live_prdv_w = live_prd.prd;
    assign live_bcnt_w = live_prd.bcnt;

    assign pwm_out     = live_duty.en && ({1'b0, cnt} < hi_cnt);
    assign prd_wrap    = wrap;

endmodule

// File: rtl/bl_pwm_chk.sv
// Checker: cycle-level properties of the backlight PWM block.
// Bound into the top. Observes ports and internal state only.
module bl_pwm_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        pwm_out,
    input logic        prd_wrap,
    input logic        upd_pending,
    input logic        lock_q,
    input logic        live_en,
    input logic [15:0] live_act,
    input logic [15:0] live_prd,
    input logic [3:0]  live_bcnt,
    input logic [15:0] cnt,
    input logic [15:0] limit
);

    // R9
    live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> ($stable(live_act) && $stable(live_en) &&
                    $stable(live_prd) && $stable(live_bcnt)));

    // R8
    live_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(live_act) && $stable(live_en) && $stable(live_prd) &&
          $stable(live_bcnt)) |-> $past(prd_wrap));

    // R8
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(upd_pending) |-> $past(prd_wrap));

    // R10
    unlock_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_q) |-> upd_pending);

    // R6
    dark_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !live_en |-> !pwm_out);

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= limit);

    // R2
    wrap_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prd_wrap |=> !prd_wrap);

endmodule

bind bl_pwm_lockupd bl_pwm_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwm_out     (pwm_out),
    .prd_wrap    (prd_wrap),
    .upd_pending (upd_pending),
    .lock_q      (lock_q),
    .live_en     (live_en_w),
    .live_act    (live_act_w),
    .live_prd    (live_prdv_w),
    .live_bcnt   (live_bcnt_w),
    .cnt         (cnt),
    .limit       (limit)
);

// File: tb/sim_bl_pwm_lockupd.sv
`timescale 1ns/1ps
// Directed bench for the backlight PWM block: one task per scenario.
module sim_bl_pwm_lockupd;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic        pwm_out;
    logic        prd_wrap;
    logic        upd_pending;

    int checks = 0;
    int failures = 0;

    localparam logic [1:0] A_PRD  = 2'd0;
    localparam logic [1:0] A_DUTY = 2'd1;
    localparam logic [1:0] A_LOCK = 2'd2;

    always #2.5 clk = ~clk;

    bl_pwm_lockupd u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .pwm_out     (pwm_out),
        .prd_wrap    (prd_wrap),
        .upd_pending (upd_pending)
    );

    task automatic check_eq(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Locked pair write so period and duty go live together.
    task automatic program_cfg(input logic [31:0] pw, input logic [31:0] dw);
        wr(A_LOCK, 32'd1);
        wr(A_PRD, pw);
        wr(A_DUTY, dw);
        wr(A_LOCK, 32'd0);
    endtask

    // Stop on the last clock of the current period (negedge sample).
    task automatic sync_wrap();
        while (!prd_wrap) @(negedge clk);
    endtask

    // Stop on the wrap that loads pending values; it must still be pending.
    task automatic commit(input string tag);
        sync_wrap();
        check_eq({tag, " pending before load"}, upd_pending, 1);
    endtask

    // Sample one period of len clocks; report high clocks and wrap placement.
    task automatic grab(input int len, output int highs, output int len_ok);
        highs = 0;
        len_ok = 1;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            highs += int'(pwm_out);
            if (prd_wrap != (i == len - 1)) len_ok = 0;
        end
    endtask

    task automatic t_reset();
        int n;
        int highs;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_eq("R1 pending after reset", upd_pending, 0);
        check_eq("R1 output at reset", pwm_out, 1);
        n = 1;
        highs = int'(pwm_out);
        while (!prd_wrap && n < 70000) begin
            @(negedge clk);
            n++;
            highs += int'(pwm_out);
        end
        check_eq("R1 default period length", n, 4001);
        check_eq("R1 default high clocks", highs, 4000);
    endtask

    task automatic t_basic();
        int h, ok;
        program_cfg(32'h0004_0009, 32'h8000_3000);
        commit("R8 basic");
        grab(10, h, ok);
        check_eq("R5 basic high clocks", h, 3);
        check_eq("R2 basic period length", ok, 1);
        check_eq("R8 pending cleared", upd_pending, 0);
    endtask

    task automatic t_mask();
        int h, ok;
        program_cfg(32'h0004_0017, 32'h8000_2000);
        commit("R2 mask");
        grab(8, h, ok);
        check_eq("R2 masked period length", ok, 1);
        check_eq("R5 masked period high", h, 2);
    endtask

    task automatic t_unlocked();
        int h, ok;
        wr(A_DUTY, 32'h8000_5000);
        check_eq("R8 unlocked write sets pending", upd_pending, 1);
        commit("R8 unlocked");
        grab(8, h, ok);
        check_eq("R8 unlocked value live", h, 5);
        check_eq("R8 pending cleared after load", upd_pending, 0);
    endtask

    task automatic t_nonfrac();
        int h, ok;
        program_cfg(32'h0004_0009, 32'h8000_3FFF);
        commit("R5 nonfrac");
        for (int p = 0; p < 3; p++) begin
            grab(10, h, ok);
            check_eq("R5 fraction ignored", h, 3);
        end
        program_cfg(32'h0004_0009, 32'h8000_F000);
        commit("R5 saturate");
        grab(10, h, ok);
        check_eq("R5 integer above limit", h, 10);
    endtask

    task automatic t_frac();
        int h, ok;
        int exp_h[4] = '{3, 4, 3, 4};
        program_cfg(32'h0004_0009, 32'hC000_3800);
        commit("R7 frac");
        for (int p = 0; p < 4; p++) begin
            grab(10, h, ok);
            check_eq("R7 dithered high clocks", h, exp_h[p]);
        end
    endtask

    task automatic t_bits16();
        int h, ok;
        program_cfg(32'h0000_0005, 32'h8000_0002);
        commit("R3 bits16");
        grab(6, h, ok);
        check_eq("R3 sixteen-bit period length", ok, 1);
        check_eq("R3 sixteen-bit integer", h, 2);
    endtask

    task automatic t_dark();
        int h, ok;
        program_cfg(32'h0004_0009, 32'h0000_5000);
        commit("R6 dark");
        grab(10, h, ok);
        check_eq("R6 disabled output high clocks", h, 0);
    endtask

    task automatic t_lock();
        int h, ok;
        program_cfg(32'h0004_0009, 32'h8000_3000);
        commit("R9 lock setup");
        grab(10, h, ok);
        check_eq("R9 setup high clocks", h, 3);
        wr(A_LOCK, 32'd1);
        wr(A_DUTY, 32'h8000_5000);
        check_eq("R9 no pending while locked", upd_pending, 0);
        sync_wrap();
        for (int p = 0; p < 2; p++) begin
            grab(10, h, ok);
            check_eq("R9 held value not live", h, 3);
        end
        check_eq("R9 still not pending", upd_pending, 0);
        wr(A_LOCK, 32'd0);
        check_eq("R10 release sets pending", upd_pending, 1);
        commit("R10 release");
        grab(10, h, ok);
        check_eq("R10 held value live after release", h, 5);
        check_eq("R10 pending cleared", upd_pending, 0);
    endtask

    task automatic t_bigperiod();
        int h, ok;
        program_cfg(32'h0004_0010, 32'h8000_3000);
        commit("R4 zero period");
        grab(65536, h, ok);
        check_eq("R4 zero masked period length", ok, 1);
        check_eq("R4 zero masked period high", h, 3);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_mask();
        t_unlocked();
        t_nonfrac();
        t_frac();
        t_bits16();
        t_dark();
        t_lock();
        t_bigperiod();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule